// File: doc/BRIEF.md
# Peripheral I/O Window Address Router

This block sits behind a 128 KB memory-mapped window of a multi-function I/O controller and turns each request offset into a target selection and a register index. The window is split by two high offset bits into a device register space, a DMA register space and a local interrupt register space. Requests bound for a peripheral leave through a shared port bundle: a one-hot strobe per target, a read/write flag, an 8-bit register index and the write data. Each target returns its read data in the same cycle. The router registers that data and presents it one cycle later.

A few device slots are served inside the router itself. One slot returns a fixed board identification word. One slot holds a page register that software loads with the byte order of its access width. One slot reaches a battery-backed byte store indirectly. The address into that store is the page register shifted left by five, plus five low offset bits. The store is a local byte array. A request that decodes to nothing returns zero and raises a one-cycle error flag.

Top module: `mio_window_router`

## Requirements
- R1: Offset bit 16 set selects device space with subdevice `off[15:12]`; otherwise bit 15 set selects DMA space; otherwise interrupt space. Target codes on `tgt_sel` are: 0 disk, 1 network, 2 serial, 3 sound control, 4 floppy, 5 VIA, 6 sound-output DMA, 7 interrupt bank. At most one strobe is high, and only while `req` is high.
- R2: Device 0 (disk, code 0) and device 5 (floppy, code 4) take `off[7:4]` as index. Device 1 (network, code 1) takes `off[8:4]`.
- R3: Device 2 with `off[7:0]` below 16 is serial (code 2), with index `{c[0], c[3:1]}` where `c = off[4:1]`. Device 2 at or above 16, and device 3, are serial with index `off[7:4]`.
- R4: Device 4 is sound control (code 3) with index `off[7:0]`. Devices 6 and 7 both select VIA (code 5) with index `off[12:9]`.
- R5: In DMA space, subdevice 8 selects the sound-output DMA (code 6) with index `off[7:0]`. In interrupt space, offsets below 0x100 select the interrupt bank (code 7) with index `off[7:0]`.
- R6: A read of device 0xA returns 0x00010000, which is the word 0x100 with its four bytes reversed.
- R7: A write to device 0xD loads the page register. With `size` = 4 the write data is byte-reversed over 32 bits. With `size` = 2 the low 16 bits are byte-swapped. Any other size loads the value unchanged.
- R8: Device 0xF reaches byte address `((page << 5) + off[8:4]) mod 2048`. A write stores `wdata[7:0]`. A read returns that byte zero-extended.
- R9: One cycle after a read request, `rvalid` is high and `rdata` holds the data of the request cycle.
- R10: The following requests are unmapped: devices 8, 9, 0xB, 0xC and 0xE; a write to 0xA; a read of 0xD; DMA subdevices other than 8; interrupt offsets of 0x100 and above. An unmapped request raises `err` one cycle later. An unmapped read returns zero. An unmapped request strobes no target and changes no state.
- R11: After reset, `rdata`, `rvalid`, `err` and the page register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid this cycle |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 3 | Access width in bytes (1, 2 or 4) |
| off | input | 17 | Offset inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle after the read |
| err | output | 1 | One-cycle pulse for an unmapped request |
| tgt_sel | output | 8 | One-hot target strobe |
| tgt_we | output | 1 | Write flag to targets |
| tgt_idx | output | 8 | Register index seen by the target |
| tgt_wdata | output | 32 | Write data to targets |
| tgt_rdata | input | 256 | Read data from targets, 32 bits per target code |

## Verification
Two functions can meet in consecutive cycles. A page register write is directly followed by a byte store access, and the store address must already use the new page. The bench provokes this with no idle cycle between the two requests. It judges the case by reading back a byte that differs between the old page and the new page. A second pairing is a mapped read followed at once by an unmapped read. That case shows whether the zero return and the error pulse replace the earlier read data in the very next cycle.

// File: rtl/mio_pkg.sv
package mio_pkg;
  localparam int WIN_AW   = 17;
  localparam int IDX_W    = 8;
  localparam int DATA_W   = 32;
  localparam int NTGT     = 8;
  localparam int TGT_W    = $clog2(NTGT);
  localparam logic [31:0] BOARD_WORD = 32'h0000_0100;

  typedef enum logic [TGT_W-1:0] {
    T_DISK, T_NET, T_SERIAL, T_SNDCTL, T_FLOPPY, T_VIA, T_SNDDMA, T_INTC
  } tgt_e;

  typedef enum logic [2:0] {
    K_PORT, K_BOARD, K_PAGE, K_STORE, K_UNMAP
  } kind_e;

  function automatic logic [3:0] serial_remap(input logic [3:0] c);
    return {c[0], c[3:1]};
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] rev16(input logic [15:0] v);
    return {16'h0, v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/mio_decode.sv
module mio_decode
  import mio_pkg::*;
(
  input  logic              we,
  input  logic [WIN_AW-1:0] off,
  output kind_e             kind,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  idx
);
  logic [3:0] sub;
  assign sub = off[15:12];

  always_comb begin
    kind = K_UNMAP;
    tgt  = T_DISK;
    idx  = '0;
    if (off[16]) begin
      unique case (sub)
        4'h0: begin kind = K_PORT; tgt = T_DISK;   idx = IDX_W'(off[7:4]); end
        4'h1: begin kind = K_PORT; tgt = T_NET;    idx = IDX_W'(off[8:4]); end
        4'h2: begin
          kind = K_PORT; tgt = T_SERIAL;
          if (off[7:0] < 8'd16) idx = IDX_W'(serial_remap(off[4:1]));
          else                  idx = IDX_W'(off[7:4]);
        end
        4'h3: begin kind = K_PORT; tgt = T_SERIAL; idx = IDX_W'(off[7:4]); end
        4'h4: begin kind = K_PORT; tgt = T_SNDCTL; idx = IDX_W'(off[7:0]); end
        4'h5: begin kind = K_PORT; tgt = T_FLOPPY; idx = IDX_W'(off[7:4]); end
        4'h6, 4'h7: begin kind = K_PORT; tgt = T_VIA; idx = IDX_W'(off[12:9]); end
        4'hA: if (!we) kind = K_BOARD;
        4'hD: if (we)  kind = K_PAGE;
        4'hF: kind = K_STORE;
        default: kind = K_UNMAP;
      endcase
    end else if (off[15]) begin
      if (sub == 4'h8) begin
        kind = K_PORT; tgt = T_SNDDMA; idx = IDX_W'(off[7:0]);
      end
    end else if (off[14:8] == '0) begin
      kind = K_PORT; tgt = T_INTC; idx = IDX_W'(off[7:0]);
    end
  end
endmodule

// File: rtl/mio_store.sv
module mio_store
  import mio_pkg::*;
#(
  parameter int ST_AW  = 11,
  parameter int PAGE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_we,
  input  logic [2:0]        size,
  input  logic [31:0]       wdata,
  input  logic              byte_we,
  input  logic [4:0]        lo,
  output logic [7:0]        rd_byte
);
  localparam int ST_BYTES = 1 << ST_AW;
  localparam int SUM_W    = PAGE_W + 6;

  logic [PAGE_W-1:0] page_q, page_d;
  logic [7:0]        mem [ST_BYTES];
  logic [SUM_W-1:0]  sum;
  logic [ST_AW-1:0]  addr;
  logic [31:0]       page_val;

  always_comb begin
    unique case (size)
      3'd4:    page_val = rev32(wdata);
      3'd2:    page_val = rev16(wdata[15:0]);
      default: page_val = wdata;
    endcase
    page_d = page_we ? PAGE_W'(page_val) : page_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end

  assign sum     = (SUM_W'(page_q) << 5) + SUM_W'(lo);
  assign addr    = sum[ST_AW-1:0];
  assign rd_byte = mem[addr];

  always_ff @(posedge clk) begin
    if (byte_we) mem[addr] <= wdata[7:0];
  end
endmodule

// File: rtl/mio_window_router.sv
module mio_window_router
  import mio_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   we,
  input  logic [2:0]             size,
  input  logic [WIN_AW-1:0]      off,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic                   rvalid,
  output logic                   err,
  output logic [NTGT-1:0]        tgt_sel,
  output logic                   tgt_we,
  output logic [IDX_W-1:0]       tgt_idx,
  output logic [DATA_W-1:0]      tgt_wdata,
  input  logic [NTGT*DATA_W-1:0] tgt_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  kind_e             kind;
  tgt_e              tgt;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        st_byte;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q, rvalid_d, err_q, err_d, cap_en;

  mio_decode u_dec (.we(we), .off(off), .kind(kind), .tgt(tgt), .idx(idx));

  mio_store u_store (
    .clk(clk), .rst_n(rst_s),
    .page_we(req && we && kind == K_PAGE),
    .size(size), .wdata(wdata),
    .byte_we(req && we && kind == K_STORE),
    .lo(off[8:4]), .rd_byte(st_byte)
  );

  for (genvar g = 0; g < NTGT; g++) begin : g_sel
    assign tgt_sel[g] = req && (kind == K_PORT) && (tgt == tgt_e'(g));
  end
  assign tgt_we    = we;
  assign tgt_idx   = idx;
  assign tgt_wdata = wdata;

  always_comb begin
    unique case (kind)
      K_PORT:  rd_mux = tgt_rdata[tgt*DATA_W +: DATA_W];
      K_BOARD: rd_mux = rev32(BOARD_WORD);
      K_STORE: rd_mux = DATA_W'(st_byte);
      default: rd_mux = '0;
    endcase
    cap_en   = req && !we;
    rdata_d  = cap_en ? rd_mux : rdata_q;
    rvalid_d = cap_en;
    err_d    = req && (kind == K_UNMAP);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
      err_q    <= err_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
  assign err    = err_q;
endmodule

// File: rtl/mio_router_chk.sv
module mio_router_chk
  import mio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [WIN_AW-1:0] off,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid,
  input logic              err,
  input logic [NTGT-1:0]   tgt_sel
);
  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));
  a_r1_sel_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (tgt_sel == '0));
  a_r9_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(req && !we));
  a_r10_err_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req));
  a_r10_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(tgt_sel) == '0));
  a_r10_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (err && rvalid) |-> (rdata == '0));
  a_r6_board_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && $past(off[16:12] == 5'h1A)) |-> (rdata == 32'h0001_0000));
endmodule

bind mio_window_router mio_router_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .off(off),
  .rdata(rdata), .rvalid(rvalid), .err(err), .tgt_sel(tgt_sel)
);

// File: tb/test_mio_window_router.sv
module test_mio_window_router;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [2:0]   size = 3'd4;
  logic [16:0]  off = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         rvalid, err, tgt_we;
  logic [7:0]   tgt_sel, tgt_idx;
  logic [31:0]  tgt_wdata;
  logic [255:0] tgt_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  for (genvar k = 0; k < 8; k++) begin : g_stub
    assign tgt_rdata[k*32 +: 32] = {8'hD0 + 8'(k), 16'h0, tgt_idx};
  end

  mio_window_router i_mio_window_router (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .off(off),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .err(err),
    .tgt_sel(tgt_sel), .tgt_we(tgt_we), .tgt_idx(tgt_idx),
    .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // read through a peripheral port: strobe and index in the cycle, data one later
  task automatic t_route(input string tag, input logic [16:0] o, input int t, input logic [7:0] ix);
    @(negedge clk); req = 1; we = 0; off = o;
    #1;
    check({tag, " strobe"}, 32'(tgt_sel), 32'(8'h1 << t));
    check({tag, " index"}, 32'(tgt_idx), 32'(ix));
    @(negedge clk); req = 0;
    check({tag, " rdata"}, rdata, {8'hD0 + 8'(t), 16'h0, ix});
    check({tag, " rvalid/err"}, {30'h0, rvalid, err}, 32'h2);
  endtask

  task automatic t_wr(input logic [2:0] s, input logic [16:0] o, input logic [31:0] d,
                      output logic e);
    @(negedge clk); req = 1; we = 1; size = s; off = o; wdata = d;
    @(negedge clk); req = 0; we = 0; e = err;
  endtask

  task automatic t_rd(input logic [16:0] o, output logic [31:0] d, output logic e,
                      output logic [7:0] sel);
    @(negedge clk); req = 1; we = 0; off = o;
    #1 sel = tgt_sel;
    @(negedge clk); req = 0; d = rdata; e = err;
  endtask

  task automatic t_reset();
    #1;
    check("R11 reset rdata", rdata, 32'h0);
    check("R11 reset rvalid/err", {30'h0, rvalid, err}, 32'h0);
    check("R1 no strobe idle", 32'(tgt_sel), 32'h0);
  endtask

  task automatic t_ports();
    t_route("R2 disk", 17'h100A0, 0, 8'h0A);
    t_route("R2 disk hi", 17'h10123, 0, 8'h02);
    t_route("R2 net", 17'h11150, 1, 8'h15);
    t_route("R2 floppy", 17'h15030, 4, 8'h03);
    t_route("R3 serial compat a", 17'h12006, 2, 8'h09);
    t_route("R3 serial compat b", 17'h1200C, 2, 8'h03);
    t_route("R3 serial dev2 hi", 17'h12070, 2, 8'h07);
    t_route("R3 serial dev3", 17'h13050, 2, 8'h05);
    t_route("R4 sound ctl", 17'h140AB, 3, 8'hAB);
    t_route("R4 via dev6", 17'h16A00, 5, 8'h05);
    t_route("R4 via dev7", 17'h17E00, 5, 8'h0F);
    t_route("R5 sound dma", 17'h08044, 6, 8'h44);
    t_route("R5 intc", 17'h00024, 7, 8'h24);
  endtask

  task automatic t_board();
    logic [31:0] d; logic e; logic [7:0] s;
    t_rd(17'h1A000, d, e, s);
    check("R6 board word", d, 32'h0001_0000);
    check("R6 board no strobe/err", {23'h0, s, e}, 32'h0);
  endtask

  task automatic t_store();
    logic [31:0] d; logic e; logic [7:0] s;
    t_wr(3'd4, 17'h1D000, 32'h0000_0000, e);     // page 0
    t_wr(3'd1, 17'h1F020, 32'h0000_0011, e);
    t_wr(3'd4, 17'h1D000, 32'h0300_0000, e);     // R7 32-bit swap -> page 3
    t_wr(3'd1, 17'h1F020, 32'hFFFF_FF5A, e);
    t_rd(17'h1F020, d, e, s);
    check("R8 store page3 byte", d, 32'h0000_005A);
    t_wr(3'd2, 17'h1D000, 32'h0000_0000, e);
    t_rd(17'h1F020, d, e, s);
    check("R7 16-bit page 0", d, 32'h0000_0011);
    t_wr(3'd2, 17'h1D000, 32'h0000_0300, e);     // R7 16-bit swap -> page 3
    t_rd(17'h1F020, d, e, s);
    check("R7 16-bit swap page 3", d, 32'h0000_005A);
    t_wr(3'd1, 17'h1D000, 32'h0000_0003, e);     // R7 byte as-is -> page 3
    t_rd(17'h1F020, d, e, s);
    check("R7 byte page 3", d, 32'h0000_005A);
    t_wr(3'd4, 17'h1D000, 32'h0000_0001, e);     // page 0x01000000, wraps to 0
    t_rd(17'h1F020, d, e, s);
    check("R8 address wrap", d, 32'h0000_0011);
  endtask

  // page write and store read with no idle cycle between them
  task automatic t_back_to_back();
    @(negedge clk); req = 1; we = 1; size = 3'd4; off = 17'h1D000; wdata = 32'h0300_0000;
    @(negedge clk); we = 0; off = 17'h1F020;
    @(negedge clk); req = 0;
    check("R8 R7 back-to-back page use", rdata, 32'h0000_005A);
  endtask

  task automatic t_unmapped();
    logic [31:0] d; logic e; logic [7:0] s;
    // mapped read then unmapped read back to back
    @(negedge clk); req = 1; we = 0; off = 17'h100A0;
    @(negedge clk); off = 17'h18000;
    #1 s = tgt_sel;
    check("R10 unmapped no strobe", 32'(s), 32'h0);
    check("R9 mapped read data", rdata, 32'hD000_000A);
    @(negedge clk); req = 0;
    check("R10 unmapped dev8 data", rdata, 32'h0);
    check("R10 unmapped dev8 err", 32'(err), 32'h1);
    @(negedge clk);
    check("R10 err one cycle", 32'(err), 32'h0);
    t_rd(17'h09000, d, e, s);
    check("R10 dma sub 9", {d[30:0], e}, 32'h1);
    t_rd(17'h00200, d, e, s);
    check("R10 intc high", {d[30:0], e}, 32'h1);
    t_rd(17'h1D000, d, e, s);
    check("R10 read page slot", {d[30:0], e}, 32'h1);
    t_wr(3'd4, 17'h1A000, 32'h1234_5678, e);
    check("R10 write board slot", 32'(e), 32'h1);
    t_wr(3'd1, 17'h1E020, 32'h0000_00EE, e);
    check("R10 write dev E", 32'(e), 32'h1);
    t_rd(17'h1F020, d, e, s);
    check("R10 store untouched", d, 32'h0000_005A);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ports();
    t_board();
    t_store();
    t_back_to_back();
    t_unmapped();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule